// File: doc/BRIEF.md
# Page Access Permission and Fault Code Checker

This block takes the attributes that a page-table walk has gathered for one translation and decides whether the requested access may go ahead. It also works out which of read, write and execute may be cached with the translation, and it builds the 6-bit page-fault error code that the fault handler will see. The supervisor write-protect override, the guard that stops supervisor code from running out of user pages, and the per-key access and write disables are all folded into one rights mask and one error code.

A request is presented for one cycle with `req_valid`. One clock edge later the verdict appears, with `rsp_valid` high for one cycle. When `rsp_valid` is low, all the result outputs are zero. The checker holds no state apart from this output register, so a new request can be issued on every cycle.

Top module: `pgperm_check`

## Requirements
- R1: The result is registered. `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. While `rsp_valid` is low, and while reset is active (synchronous, active-low), `rsp_allow`, `rsp_rights` and `rsp_err` are zero.
- R2: When the walker reports the page as not present, the access faults with `rsp_allow` = 0 and `rsp_rights` = 0, and error-code bit 0 is clear, whatever the other inputs are.
- R3: A page that is present but has the reserved-bit flag set faults. Error-code bit 3 (reserved) and bit 0 (present) are both set.
- R4: A user-mode access (`acc_user` = 1) to a page whose user bit is clear is a protection fault. Error-code bit 0 and bit 2 are set.
- R5: Rights are encoded as bit 0 read, bit 1 write and bit 2 execute. Read is always granted. Write is granted if the page is writable, or if the access is in supervisor mode and `ctl_wp` = 0. Access type is encoded 0 = read, 1 = write, 2 = fetch, and 3 is handled as a read.
- R6: Execute is granted only if the no-execute bit is clear and either the access is in user mode or it is not the case that `ctl_sup_exec_guard` = 1 on a user page.
- R7: Key checks apply only when `ctl_key_en` = 1, the page is a user page and `key_rights` is nonzero. For page key k, bit 2k removes read and write, and bit 2k+1 removes write only when the access is in user mode or `ctl_wp` = 1. Execute is never removed by a key.
- R8: An access denied by its key sets error-code bit 5 (key) together with bit 0.
- R9: An access is allowed when the rights left after R5 to R7 contain the bit for the access type. It then gives `rsp_allow` = 1, the rights mask and `rsp_err` = 0. Otherwise it is a protection fault with error-code bit 0 set.
- R10: On every fault, error-code bit 1 is set exactly for write accesses and bit 2 exactly for user-mode accesses.
- R11: On a fault, error-code bit 4 (fetch) is set only for fetches, and only when either `ctl_nxe` and `ctl_wide_pte` are both 1 or `ctl_sup_exec_guard` is 1.
- R12: Fault precedence is not-present, then reserved, then user-on-supervisor-page, then key denial, then rights denial. Every fault reports `rsp_rights` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| pg_user | input | 1 | Combined user bit of the walk |
| pg_write | input | 1 | Combined writable bit of the walk |
| pg_nx | input | 1 | Combined no-execute bit of the walk |
| walk_notpresent | input | 1 | The walker found an entry not present |
| walk_rsvd | input | 1 | The walker found a reserved bit set |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_user | input | 1 | 1 = user-mode access |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_wide_pte | input | 1 | Extended (wide-entry) paging in use |
| ctl_sup_exec_guard | input | 1 | Blocks supervisor execution from user pages |
| ctl_key_en | input | 1 | Protection-key enable |
| pg_key | input | KEY_BITS | Key number of the page |
| key_rights | input | 2*2^KEY_BITS | Two disable bits per key |
| rsp_valid | output | 1 | Result is valid |
| rsp_allow | output | 1 | The access is permitted |
| rsp_rights | output | 3 | Cached rights: bit 0 read, bit 1 write, bit 2 exec |
| rsp_err | output | 6 | Fault code: 0 present, 1 write, 2 user, 3 reserved, 4 fetch, 5 key |

## Verification
The hardest case to reach from the ports is the key write-disable that depends on mode. A supervisor write to a writable user page must pass while `ctl_wp` is 0 and fail with the key bit once `ctl_wp` is 1. To get there, the stimulus has to combine a user page, key protection enabled, a nonzero rights word whose bit sits at exactly 2k+1 for the page's key, and a supervisor store. The directed cases pin down this combination, a key-disabled fetch that must still pass, and the bits for neighbouring keys. After that, a long stream of unconstrained requests is compared, one request per cycle, against a reference model in the bench, so that each fault precedence meets every combination of controls.

// File: rtl/pgperm_pkg.sv
// Package pgperm_pkg
// Shared encodings for the page permission checker: access types,
// rights bit positions and error-code bit positions.
// Assumes the rights mask and access type use the same bit index.
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    localparam int RIGHT_W = 3;
    localparam int RT_RD   = 0;
    localparam int RT_WR   = 1;
    localparam int RT_EX   = 2;

    localparam int ERR_W  = 6;
    localparam int E_PRES = 0;
    localparam int E_WR   = 1;
    localparam int E_USR  = 2;
    localparam int E_RSV  = 3;
    localparam int E_FET  = 4;
    localparam int E_KEY  = 5;

    typedef logic [RIGHT_W-1:0] rights_t;

    // Rights bit that an access type needs (the alternate code reads).
    function automatic logic [1:0] need_idx(input acc_e a);
        case (a)
            ACC_STORE: need_idx = 2'(RT_WR);
            ACC_FETCH: need_idx = 2'(RT_EX);
            default:   need_idx = 2'(RT_RD);
        endcase
    endfunction

endpackage

// File: rtl/pgperm_base_rights.sv
// Module pgperm_base_rights
// Derives the read/write/execute rights from the combined page bits and
// the mode controls, before any key restriction.
// Assumes the page bits are already combined across all walk levels.
module pgperm_base_rights
    import pgperm_pkg::*;
(
    input  logic    pg_user,
    input  logic    pg_write,
    input  logic    pg_nx,
    input  logic    acc_user,
    input  logic    ctl_wp,
    input  logic    ctl_guard,
    output rights_t base
);

    logic wr_ok;
    logic ex_ok;

    // Write: page writable, or supervisor with write-protect off.
    always_comb begin
        wr_ok = pg_write | (~acc_user & ~ctl_wp);
    end

    // Execute: no-execute clear and the supervisor guard not tripped.
    always_comb begin
        ex_ok = ~pg_nx & (acc_user | ~(ctl_guard & pg_user));
    end

    // Assemble the mask; reads are always granted here.
    always_comb begin
        base        = '0;
        base[RT_RD] = 1'b1;
        base[RT_WR] = wr_ok;
        base[RT_EX] = ex_ok;
    end

endmodule

// File: rtl/pgperm_key_filter.sv
// Module pgperm_key_filter
// Turns the per-key rights word into a mask over read/write/execute.
// Each key owns two adjacent bits: the lower disables data access,
// the upper disables writes. Keys never remove execute.
module pgperm_key_filter
    import pgperm_pkg::*;
#(
    parameter  int KEY_BITS  = 4,
    localparam int NKEYS     = 1 << KEY_BITS,
    localparam int KEY_REG_W = 2 * NKEYS
) (
    input  logic                 pg_user,
    input  logic                 acc_user,
    input  logic                 ctl_wp,
    input  logic                 ctl_key_en,
    input  logic [KEY_BITS-1:0]  pg_key,
    input  logic [KEY_REG_W-1:0] key_rights,
    output logic                 key_active,
    output rights_t              key_mask
);

    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    // Split the rights word into per-key access- and write-disable lanes.
    for (genvar k = 0; k < NKEYS; k++) begin : g_lane
        assign ad_vec[k] = key_rights[2*k];
        assign wd_vec[k] = key_rights[2*k+1];
    end

    logic ad_sel;
    logic wd_sel;

    // Pick the lanes of the page's key.
    always_comb begin
        ad_sel = ad_vec[pg_key];
        wd_sel = wd_vec[pg_key];
    end

    // Keys matter only for user pages with keys on and a nonzero word.
    always_comb begin
        key_active = ctl_key_en & pg_user & (|key_rights);
    end

    // Build the mask; write-disable needs user mode or write-protect.
    always_comb begin
        key_mask = '1;
        if (key_active) begin
            if (ad_sel) begin
                key_mask[RT_RD] = 1'b0;
                key_mask[RT_WR] = 1'b0;
            end else if (wd_sel && (acc_user || ctl_wp)) begin
                key_mask[RT_WR] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgperm_fault_code.sv
// Module pgperm_fault_code
// Ranks the fault causes, forms the verdict and the rights to cache,
// and builds the error code. Precedence: not present, reserved,
// user on supervisor page, key denial, rights denial.
module pgperm_fault_code
    import pgperm_pkg::*;
(
    input  logic             walk_notpresent,
    input  logic             walk_rsvd,
    input  acc_e             acc,
    input  logic             acc_user,
    input  logic             pg_user,
    input  rights_t          base,
    input  rights_t          key_mask,
    input  logic             key_active,
    input  logic             ctl_nxe,
    input  logic             ctl_wide_pte,
    input  logic             ctl_guard,
    output logic             allow,
    output rights_t          rights,
    output logic [ERR_W-1:0] err
);

    rights_t    comb;
    logic [1:0] idx;
    logic       f_np, f_rsv, f_usr, f_key, f_prot, fault;

    // Merge the base rights with the key mask when keys apply.
    always_comb begin
        comb = key_active ? (base & key_mask) : base;
        idx  = need_idx(acc);
    end

    // Rank the fault causes so that exactly one of them wins.
    always_comb begin
        f_np   = walk_notpresent;
        f_rsv  = ~f_np & walk_rsvd;
        f_usr  = ~f_np & ~f_rsv & acc_user & ~pg_user;
        f_key  = ~f_np & ~f_rsv & ~f_usr & key_active & ~key_mask[idx];
        f_prot = ~f_np & ~f_rsv & ~f_usr & ~f_key & ~comb[idx];
        fault  = f_np | f_rsv | f_usr | f_key | f_prot;
    end

    // Verdict and cached rights; any fault clears the rights.
    always_comb begin
        allow  = ~fault;
        rights = fault ? '0 : comb;
    end

    // Error code, zero for allowed accesses.
    always_comb begin
        err = '0;
        if (fault) begin
            err[E_PRES] = f_rsv | f_usr | f_key | f_prot;
            err[E_WR]   = (acc == ACC_STORE);
            err[E_USR]  = acc_user;
            err[E_RSV]  = f_rsv;
            err[E_FET]  = (acc == ACC_FETCH) & ((ctl_nxe & ctl_wide_pte) | ctl_guard);
            err[E_KEY]  = f_key;
        end
    end

endmodule

// File: rtl/pgperm_check.sv
// Module pgperm_check
// Top of the page permission checker. Combines the base rights, the key
// filter and the fault ranking, and registers the result for one cycle.
// Assumes the walk results are stable within the cycle of req_valid.
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter  int KEY_BITS  = 4,
    localparam int KEY_REG_W = 2 * (1 << KEY_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 pg_user,
    input  logic                 pg_write,
    input  logic                 pg_nx,
    input  logic                 walk_notpresent,
    input  logic                 walk_rsvd,
    input  logic [1:0]           acc_type,
    input  logic                 acc_user,
    input  logic                 ctl_wp,
    input  logic                 ctl_nxe,
    input  logic                 ctl_wide_pte,
    input  logic                 ctl_sup_exec_guard,
    input  logic                 ctl_key_en,
    input  logic [KEY_BITS-1:0]  pg_key,
    input  logic [KEY_REG_W-1:0] key_rights,
    output logic                 rsp_valid,
    output logic                 rsp_allow,
    output logic [2:0]           rsp_rights,
    output logic [5:0]           rsp_err
);

    acc_e             acc;
    rights_t          base_r;
    rights_t          kmask;
    logic             kact;
    logic             allow_c;
    rights_t          rights_c;
    logic [ERR_W-1:0] err_c;

    // Give the raw access code its enumerated meaning.
    always_comb begin
        acc = acc_e'(acc_type);
    end

    pgperm_base_rights u_base (
        .pg_user   (pg_user),
        .pg_write  (pg_write),
        .pg_nx     (pg_nx),
        .acc_user  (acc_user),
        .ctl_wp    (ctl_wp),
        .ctl_guard (ctl_sup_exec_guard),
        .base      (base_r)
    );

    pgperm_key_filter #(.KEY_BITS(KEY_BITS)) u_key (
        .pg_user    (pg_user),
        .acc_user   (acc_user),
        .ctl_wp     (ctl_wp),
        .ctl_key_en (ctl_key_en),
        .pg_key     (pg_key),
        .key_rights (key_rights),
        .key_active (kact),
        .key_mask   (kmask)
    );

    pgperm_fault_code u_fault (
        .walk_notpresent (walk_notpresent),
        .walk_rsvd       (walk_rsvd),
        .acc             (acc),
        .acc_user        (acc_user),
        .pg_user         (pg_user),
        .base            (base_r),
        .key_mask        (kmask),
        .key_active      (kact),
        .ctl_nxe         (ctl_nxe),
        .ctl_wide_pte    (ctl_wide_pte),
        .ctl_guard       (ctl_sup_exec_guard),
        .allow           (allow_c),
        .rights          (rights_c),
        .err             (err_c)
    );

    // Register the verdict; idle cycles and reset leave zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_rights <= '0;
            rsp_err    <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_allow  <= req_valid & allow_c;
            rsp_rights <= req_valid ? rights_c : '0;
            rsp_err    <= req_valid ? err_c : '0;
        end
    end

endmodule

// File: rtl/pgperm_check_sva.sv
// Module pgperm_check_sva
// Checker bound to pgperm_check. It relates the registered result to
// the request seen one cycle earlier.
module pgperm_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       pg_user,
    input logic       walk_notpresent,
    input logic       walk_rsvd,
    input logic [1:0] acc_type,
    input logic       acc_user,
    input logic       ctl_nxe,
    input logic       ctl_wide_pte,
    input logic       ctl_sup_exec_guard,
    input logic       rsp_valid,
    input logic       rsp_allow,
    input logic [2:0] rsp_rights,
    input logic [5:0] rsp_err
);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && rsp_rights == 3'd0 && rsp_err == 6'd0));

    p_notpresent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(walk_notpresent)) |->
            (!rsp_allow && rsp_rights == 3'd0 && !rsp_err[0]));

    p_rsvd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(walk_rsvd && !walk_notpresent)) |->
            (!rsp_allow && rsp_err[3] && rsp_err[0]));

    p_user_on_sup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc_user && !pg_user && !walk_notpresent)) |->
            (!rsp_allow && rsp_err[2] && rsp_err[0]));

    p_key_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err[5]) |-> (rsp_err[0] && !rsp_allow));

    p_allow_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> (rsp_err == 6'd0));

    p_write_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> (rsp_err[1] == $past(acc_type == 2'd1)));

    p_fetch_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err[4]) |->
            $past(acc_type == 2'd2 && ((ctl_nxe && ctl_wide_pte) || ctl_sup_exec_guard)));

    p_fault_rights_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> (rsp_rights == 3'd0));

endmodule

bind pgperm_check pgperm_check_sva u_sva (
    .clk                (clk),
    .rst_n              (rst_n),
    .pg_user            (pg_user),
    .walk_notpresent    (walk_notpresent),
    .walk_rsvd          (walk_rsvd),
    .acc_type           (acc_type),
    .acc_user           (acc_user),
    .ctl_nxe            (ctl_nxe),
    .ctl_wide_pte       (ctl_wide_pte),
    .ctl_sup_exec_guard (ctl_sup_exec_guard),
    .rsp_valid          (rsp_valid),
    .rsp_allow          (rsp_allow),
    .rsp_rights         (rsp_rights),
    .rsp_err            (rsp_err)
);

// File: tb/sim_pgperm_check.sv
// Scoreboard bench for pgperm_check: a driver task computes the expected
// result from the requirements and queues it, a monitor pops and compares.
module sim_pgperm_check;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        pg_user = 1'b0, pg_write = 1'b0, pg_nx = 1'b0;
    logic        walk_notpresent = 1'b0, walk_rsvd = 1'b0;
    logic [1:0]  acc_type = 2'd0;
    logic        acc_user = 1'b0, ctl_wp = 1'b0, ctl_nxe = 1'b0;
    logic        ctl_wide_pte = 1'b0, ctl_sup_exec_guard = 1'b0, ctl_key_en = 1'b0;
    logic [3:0]  pg_key = 4'd0;
    logic [31:0] key_rights = 32'd0;
    logic        rsp_valid, rsp_allow;
    logic [2:0]  rsp_rights;
    logic [5:0]  rsp_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgperm_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx),
        .walk_notpresent(walk_notpresent), .walk_rsvd(walk_rsvd),
        .acc_type(acc_type), .acc_user(acc_user), .ctl_wp(ctl_wp),
        .ctl_nxe(ctl_nxe), .ctl_wide_pte(ctl_wide_pte),
        .ctl_sup_exec_guard(ctl_sup_exec_guard), .ctl_key_en(ctl_key_en),
        .pg_key(pg_key), .key_rights(key_rights),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_rights(rsp_rights), .rsp_err(rsp_err)
    );

    // Reference: {allow, rights[2:0], err[5:0]} from the requirement text.
    function automatic logic [9:0] model(
        input logic u, w, nx, np, rs, input logic [1:0] at,
        input logic au, wp, nxe, wide, grd, ken,
        input logic [3:0] k, input logic [31:0] kr);
        logic [2:0] r, km;
        logic       kact, fnp, frs, fus, fky, fpr, flt;
        int         ix;
        logic [5:0] e;
        ix = (at == 2'd1) ? 1 : (at == 2'd2) ? 2 : 0;
        r  = {~nx & (au | ~(grd & u)), w | (~au & ~wp), 1'b1};
        kact = ken & u & (kr != 0);
        km = 3'b111;
        if (kact) begin
            if (kr[2*k]) km = 3'b100;
            else if (kr[2*k+1] && (au || wp)) km = 3'b101;
            r = r & km;
        end
        fnp = np;
        frs = !fnp && rs;
        fus = !fnp && !frs && au && !u;
        fky = !fnp && !frs && !fus && kact && !km[ix];
        fpr = !fnp && !frs && !fus && !fky && !r[ix];
        flt = fnp | frs | fus | fky | fpr;
        e = 6'd0;
        if (flt) begin
            e[0] = frs | fus | fky | fpr;
            e[1] = (at == 2'd1);
            e[2] = au;
            e[3] = frs;
            e[4] = (at == 2'd2) && ((nxe && wide) || grd);
            e[5] = fky;
        end
        return {~flt, flt ? 3'b000 : r, e};
    endfunction

    // Driver: apply one request for one cycle and queue its expectation.
    task automatic send(input string tag,
        input logic u, w, nx, np, rs, input logic [1:0] at,
        input logic au, wp, nxe, wide, grd, ken,
        input logic [3:0] k, input logic [31:0] kr);
        @(negedge clk);
        req_valid = 1'b1;
        pg_user = u; pg_write = w; pg_nx = nx;
        walk_notpresent = np; walk_rsvd = rs; acc_type = at;
        acc_user = au; ctl_wp = wp; ctl_nxe = nxe; ctl_wide_pte = wide;
        ctl_sup_exec_guard = grd; ctl_key_en = ken; pg_key = k; key_rights = kr;
        sb.push_back('{model(u, w, nx, np, rs, at, au, wp, nxe, wide, grd, ken, k, kr), tag});
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare every valid result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1 actual=unexpected result expected=no result");
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, {22'd0, rsp_allow, rsp_rights, rsp_err}, {22'd0, it.exp});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset dominates a pending request.
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset", {28'd0, rsp_valid, rsp_allow, rsp_rights, rsp_err}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {28'd0, rsp_valid, rsp_allow, rsp_rights, rsp_err}, 32'd0);

        // R1: single request gives exactly one valid cycle one edge later.
        send("R5 sup read ro wp", 0,0,0,0,0, 2'd0, 0,1,0,0,0,0, 4'd0, 32'd0);
        idle();
        chk("R1 latency", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R1 single pulse", {31'd0, rsp_valid}, 32'd0);

        // u w nx np rs at au wp nxe wide grd ken key rights
        send("R5 sup write wp off", 0,0,0,0,0, 2'd1, 0,0,0,0,0,0, 4'd0, 32'd0);
        send("R5 sup write wp on",  0,0,0,0,0, 2'd1, 0,1,0,0,0,0, 4'd0, 32'd0);
        send("R5 alt code reads",   1,0,1,0,0, 2'd3, 1,1,0,0,0,0, 4'd0, 32'd0);
        send("R4 user on sup page", 0,1,0,0,0, 2'd0, 1,0,0,0,0,0, 4'd0, 32'd0);
        send("R2 not present",      1,1,0,1,1, 2'd1, 1,0,0,0,0,0, 4'd0, 32'd0);
        send("R3 reserved",         0,1,0,0,1, 2'd0, 0,0,0,0,0,0, 4'd0, 32'd0);
        send("R12 rsvd over user",  0,1,0,0,1, 2'd1, 1,0,0,0,0,0, 4'd0, 32'd0);
        send("R6 nx fetch",         1,1,1,0,0, 2'd2, 1,0,1,1,0,0, 4'd0, 32'd0);
        send("R11 no fetch bit",    1,1,1,0,0, 2'd2, 1,0,1,0,0,0, 4'd0, 32'd0);
        send("R6 guard sup fetch",  1,1,0,0,0, 2'd2, 0,0,0,0,1,0, 4'd0, 32'd0);
        send("R6 guard user fetch", 1,1,0,0,0, 2'd2, 1,0,0,0,1,0, 4'd0, 32'd0);
        send("R7 key AD read",      1,1,0,0,0, 2'd0, 1,0,0,0,0,1, 4'd3, 32'h0000_0040);
        send("R8 key AD write",     1,1,0,0,0, 2'd1, 1,0,0,0,0,1, 4'd3, 32'h0000_0040);
        send("R7 key AD fetch ok",  1,1,0,0,0, 2'd2, 1,0,0,0,0,1, 4'd3, 32'h0000_0040);
        send("R7 WD sup wp off",    1,1,0,0,0, 2'd1, 0,0,0,0,0,1, 4'd2, 32'h0000_0020);
        send("R7 WD sup wp on",     1,1,0,0,0, 2'd1, 0,1,0,0,0,1, 4'd2, 32'h0000_0020);
        send("R7 WD user read",     1,1,0,0,0, 2'd0, 1,0,0,0,0,1, 4'd2, 32'h0000_0020);
        send("R7 other key lanes",  1,1,0,0,0, 2'd1, 1,0,0,0,0,1, 4'd2, 32'hFFFF_FF0F);
        send("R7 key top lane",     1,1,0,0,0, 2'd0, 1,0,0,0,0,1, 4'd15, 32'h4000_0000);
        send("R7 keys disabled",    1,1,0,0,0, 2'd1, 1,0,0,0,0,0, 4'd3, 32'h0000_00C0);
        send("R7 key on sup page",  0,1,0,0,0, 2'd1, 0,0,0,0,0,1, 4'd3, 32'h0000_00C0);
        send("R10 user write ok",   1,1,1,0,0, 2'd1, 1,1,0,0,0,0, 4'd0, 32'd0);
        send("R10 user write ro",   1,0,0,0,0, 2'd1, 1,0,0,0,0,0, 4'd0, 32'd0);
        send("R12 np all open",     1,1,0,1,0, 2'd0, 0,0,0,0,0,0, 4'd0, 32'd0);
        send("R9 all open fetch",   1,1,0,0,0, 2'd2, 1,0,1,1,0,0, 4'd0, 32'd0);

        // R9: back-to-back unconstrained requests against the model.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            send("R9 random", a[0], a[1], a[2], (a[3] & a[4]), (a[5] & a[6]),
                 a[8:7], a[9], a[10], a[11], a[12], a[13], a[14], a[18:15],
                 a[19] ? 32'd0 : (b & {32{a[20]}}) | (32'd1 << a[25:21]));
        end
        idle();
        repeat (3) @(negedge clk);
        chk("R1 queue drained", sb.size(), 32'd0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule